// File: doc/BRIEF.md
# Transmit Descriptor Ring Gather Engine

This block serves the transmit side of a packet port whose driver keeps a ring of two-word descriptors in host memory. When a ring start address has been programmed and the link is up, the engine repeatedly fetches the descriptor at the current pointer. If software has handed that descriptor over, the engine follows the chain of descriptors linked by the continue flag. It copies each buffer byte by byte into an internal packet memory. When the chain ends, it streams the assembled packet out one byte per cycle with a last marker. It then hands the descriptors back to software and pulses an interrupt.

Descriptor word 0 holds the ownership flag in bit 31, the wrap flag in bit 30, the continue flag in bit 27 and the buffer length in bits 12:0. Word 1 holds the byte address of the buffer. Memory is accessed through a simple request/acknowledge master whose address is a byte address that is always a multiple of four. Byte lane k of a data word holds the byte at address offset k, so the lane sits at bits 8k+7:8k. Software reaches the ring start at register offset 0x04 and the current pointer at offset 0x08. Register writes take effect only while the engine is idle.

The controller is a single state machine. Its states are:
- IDLE: waits for a non-zero ring start with the link up.
- HEAD: reads word 0.
- BPTR: reads word 1 and applies the address fixup.
- FETCH: reads one buffer byte per memory access.
- CLEAR: zeroes a non-first descriptor, then advances the pointer.
- EMIT: streams the packet.
- WBACK: rewrites the first descriptor.
- DONE: raises the interrupt.

Its transitions are:
- IDLE to HEAD when the engine is enabled.
- HEAD to IDLE when the descriptor is not owned.
- HEAD to BPTR when it is owned.
- BPTR to FETCH when the length is non-zero, otherwise to CLEAR.
- FETCH to CLEAR after the last byte.
- CLEAR to HEAD when continue is set, otherwise to EMIT when the gathered total is non-zero, otherwise to WBACK.
- EMIT to WBACK after the last byte.
- WBACK to DONE.
- DONE to IDLE.

Top module: `txring_gather`

## Requirements
- R1: No memory access and no packet occurs while the ring start register is zero or link_up is low; an unowned descriptor (bit 31 of word 0 clear) at the current pointer produces no packet, no memory write and no interrupt.
- R2: The packet consists of the buffer bytes in ascending address order, each taken from byte lane addr[1:0] of the fetched word; pkt_valid is high on consecutive cycles and pkt_last is high only with the final byte.
- R3: While bit 27 (continue) of word 0 is set, the next descriptor is also gathered into the same packet; a descriptor with length (bits 12:0) zero adds no bytes but is still consumed.
- R4: A descriptor in a chain, other than the first, found without ownership aborts the operation: no packet, no interrupt, the first descriptor stays unchanged and the current pointer is left at the unowned descriptor.
- R5: Word 0 of every consumed descriptor other than the first is overwritten with zero.
- R6: A buffer address whose bits 31:30 are both 1 is used with those two bits cleared; any other address is used unchanged.
- R7: After each consumed descriptor the current pointer moves to the ring start if bit 30 (wrap) was set, otherwise it advances by 8.
- R8: A chain whose total length is zero emits no packet but is still written back and still raises the interrupt.
- R9: On completion word 0 of the first descriptor is rewritten with only bit 31 cleared, and irq is then high for exactly one cycle.
- R10: At most MAX_BYTES (8192) bytes are emitted; bytes beyond that limit are dropped.
- R11: A register read at offset 0x04 returns the ring start, at 0x08 the current pointer, and at any other offset zero; writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Output link attached and enabled |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| pkt_valid | output | 1 | Packet byte valid |
| pkt_data | output | 8 | Packet byte |
| pkt_last | output | 1 | Final byte of the packet |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench memory raises its acknowledge one cycle after it sees a request, so each descriptor word and each buffer byte costs two cycles. The packet begins in the cycle after the last descriptor clear. Its bytes follow on back-to-back cycles. The first-descriptor rewrite lands two cycles after the last byte, and irq follows in the next cycle. Packet bytes, last markers, interrupt cycles and memory writes are recorded by monitors that sample on the falling edge. Each scenario therefore waits for the interrupt, or for a fixed quiet window when nothing may happen, before comparing what was recorded with values derived from the requirements.

// File: rtl/txg_pkg.sv
package txg_pkg;

    localparam int WORD_W     = 32;
    localparam int OWN_POS    = 31;
    localparam int WRAP_POS   = 30;
    localparam int CONT_POS   = 27;
    localparam int LEN_W      = 13;
    localparam int DESC_BYTES = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HEAD,
        S_BPTR,
        S_FETCH,
        S_CLEAR,
        S_EMIT,
        S_WBACK,
        S_DONE
    } txg_state_e;

    function automatic logic [WORD_W-1:0] fix_addr(input logic [WORD_W-1:0] a);
        return (a[31:30] == 2'b11) ? {2'b00, a[29:0]} : a;
    endfunction

endpackage

// File: rtl/txg_regs.sv
module txg_regs
    import txg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              cur_ld,
    input  logic [WORD_W-1:0] cur_nxt,
    output logic [WORD_W-1:0] ring_start,
    output logic [WORD_W-1:0] ring_cur
);

    localparam logic [3:0] OFS_START = 4'h4;
    localparam logic [3:0] OFS_CUR   = 4'h8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_start <= '0;
            ring_cur   <= '0;
        end else if (cur_ld) begin
            ring_cur <= cur_nxt;
        end else if (reg_we && !lock) begin
            if (reg_addr == OFS_START) ring_start <= reg_wdata;
            if (reg_addr == OFS_CUR)   ring_cur   <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_START: reg_rdata = ring_start;
            OFS_CUR:   reg_rdata = ring_cur;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/txg_pktbuf.sv
module txg_pktbuf #(
    parameter  int MAX_BYTES = 8192,
    localparam int IDX_W     = $clog2(MAX_BYTES),
    localparam int NWORDS    = MAX_BYTES / 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);

    logic [7:0] lane_out [4];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] store [NWORDS];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx[1:0] == 2'(g)))
                store[wr_idx[IDX_W-1:2]] <= wr_byte;
        end
        assign lane_out[g] = store[rd_idx[IDX_W-1:2]];
    end

    assign rd_byte = lane_out[rd_idx[1:0]];

endmodule

// File: rtl/txg_fsm.sv
module txg_fsm
    import txg_pkg::*;
#(
    parameter  int MAX_BYTES = 8192,
    localparam int CNT_W     = $clog2(MAX_BYTES + 1),
    localparam int IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic [WORD_W-1:0] ring_start,
    input  logic [WORD_W-1:0] ring_cur,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              pkt_valid,
    output logic              pkt_last,
    output logic              irq,
    output logic              busy,
    output logic              cur_ld,
    output logic [WORD_W-1:0] cur_nxt,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_widx,
    output logic [7:0]        buf_wbyte,
    output logic [IDX_W-1:0]  buf_ridx
);

    txg_state_e state_q, state_d;

    logic              first_q;
    logic [WORD_W-1:0] first_addr_q;
    logic [WORD_W-1:0] first_w0_q;
    logic              own_q, wrap_q, cont_q;
    logic [LEN_W-1:0]  remain_q;
    logic [WORD_W-1:0] baddr_q;
    logic [CNT_W-1:0]  tot_q;
    logic [CNT_W-1:0]  emit_q;
    logic              advance;
    logic              emit_end;
    logic [7:0]        lane_byte;

    assign advance  = (state_q == S_CLEAR) && (first_q || mem_ack);
    assign emit_end = (emit_q == tot_q - CNT_W'(1));

    always_comb begin
        unique case (baddr_q[1:0])
            2'd0: lane_byte = mem_rdata[7:0];
            2'd1: lane_byte = mem_rdata[15:8];
            2'd2: lane_byte = mem_rdata[23:16];
            2'd3: lane_byte = mem_rdata[31:24];
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (ring_start != '0 && link_up) state_d = S_HEAD;
            S_HEAD:  if (mem_ack) state_d = mem_rdata[OWN_POS] ? S_BPTR : S_IDLE;
            S_BPTR:  if (mem_ack) state_d = (remain_q != '0) ? S_FETCH : S_CLEAR;
            S_FETCH: if (mem_ack && remain_q == LEN_W'(1)) state_d = S_CLEAR;
            S_CLEAR: if (advance) begin
                if (cont_q)              state_d = S_HEAD;
                else if (tot_q != '0)    state_d = S_EMIT;
                else                     state_d = S_WBACK;
            end
            S_EMIT:  if (emit_end) state_d = S_WBACK;
            S_WBACK: if (mem_ack) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            first_q      <= 1'b0;
            first_addr_q <= '0;
            first_w0_q   <= '0;
            own_q        <= 1'b0;
            wrap_q       <= 1'b0;
            cont_q       <= 1'b0;
            remain_q     <= '0;
            baddr_q      <= '0;
            tot_q        <= '0;
            emit_q       <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: begin
                    first_q      <= 1'b1;
                    first_addr_q <= ring_cur;
                    tot_q        <= '0;
                end
                S_HEAD: if (mem_ack) begin
                    own_q    <= mem_rdata[OWN_POS];
                    wrap_q   <= mem_rdata[WRAP_POS];
                    cont_q   <= mem_rdata[CONT_POS];
                    remain_q <= mem_rdata[LEN_W-1:0];
                    if (first_q) first_w0_q <= mem_rdata;
                end
                S_BPTR: if (mem_ack) baddr_q <= fix_addr(mem_rdata);
                S_FETCH: if (mem_ack) begin
                    baddr_q  <= baddr_q + WORD_W'(1);
                    remain_q <= remain_q - LEN_W'(1);
                    if (tot_q < CNT_W'(MAX_BYTES)) tot_q <= tot_q + CNT_W'(1);
                end
                S_CLEAR: if (advance) begin
                    first_q <= 1'b0;
                    emit_q  <= '0;
                end
                S_EMIT:  emit_q <= emit_q + CNT_W'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pkt_valid = 1'b0;
        pkt_last  = 1'b0;
        irq       = 1'b0;
        cur_ld    = 1'b0;
        cur_nxt   = wrap_q ? ring_start : ring_cur + WORD_W'(DESC_BYTES);
        buf_we    = 1'b0;
        buf_widx  = tot_q[IDX_W-1:0];
        buf_wbyte = lane_byte;
        buf_ridx  = emit_q[IDX_W-1:0];
        busy      = (state_q != S_IDLE);
        unique case (state_q)
            S_HEAD: begin
                mem_req  = 1'b1;
                mem_addr = ring_cur;
            end
            S_BPTR: begin
                mem_req  = 1'b1;
                mem_addr = ring_cur + WORD_W'(4);
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {baddr_q[WORD_W-1:2], 2'b00};
                buf_we   = mem_ack && (tot_q < CNT_W'(MAX_BYTES));
            end
            S_CLEAR: begin
                mem_req  = !first_q;
                mem_we   = !first_q;
                mem_addr = ring_cur;
                cur_ld   = advance && own_q;
            end
            S_EMIT: begin
                pkt_valid = 1'b1;
                pkt_last  = emit_end;
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = first_addr_q;
                mem_wdata = first_w0_q & ~(WORD_W'(1) << OWN_POS);
            end
            S_DONE:  irq = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/txring_gather.sv
module txring_gather
    import txg_pkg::*;
#(
    parameter  int MAX_BYTES = 8192,
    localparam int IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_up,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        pkt_valid,
    output logic [7:0]  pkt_data,
    output logic        pkt_last,
    output logic        irq
);

    logic [WORD_W-1:0] ring_start, ring_cur, cur_nxt;
    logic              cur_ld, busy, buf_we;
    logic [IDX_W-1:0]  buf_widx, buf_ridx;
    logic [7:0]        buf_wbyte;

    txg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (busy),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cur_ld    (cur_ld),
        .cur_nxt   (cur_nxt),
        .ring_start(ring_start),
        .ring_cur  (ring_cur)
    );

    txg_fsm #(.MAX_BYTES(MAX_BYTES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .ring_start(ring_start),
        .ring_cur  (ring_cur),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pkt_valid (pkt_valid),
        .pkt_last  (pkt_last),
        .irq       (irq),
        .busy      (busy),
        .cur_ld    (cur_ld),
        .cur_nxt   (cur_nxt),
        .buf_we    (buf_we),
        .buf_widx  (buf_widx),
        .buf_wbyte (buf_wbyte),
        .buf_ridx  (buf_ridx)
    );

    txg_pktbuf #(.MAX_BYTES(MAX_BYTES)) u_buf (
        .clk    (clk),
        .wr_en  (buf_we),
        .wr_idx (buf_widx),
        .wr_byte(buf_wbyte),
        .rd_idx (buf_ridx),
        .rd_byte(pkt_data)
    );

endmodule

// File: rtl/txg_checks.sv
module txg_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        link_up,
    input logic        busy,
    input logic [31:0] ring_start,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_wdata,
    input logic        pkt_valid,
    input logic        pkt_last,
    input logic        irq
);

    a_r1_quiet_without_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_start == 32'd0) |-> !mem_req);

    a_r1_quiet_link_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && !busy) |=> !mem_req);

    a_r2_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_last |-> pkt_valid);

    a_r2_stream_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_last) |=> pkt_valid);

    a_r9_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r9_writes_drop_ownership: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);

endmodule

bind txring_gather txg_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up   (link_up),
    .busy      (busy),
    .ring_start(ring_start),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .pkt_valid (pkt_valid),
    .pkt_last  (pkt_last),
    .irq       (irq)
);

// File: tb/txring_gather_tb.sv
module txring_gather_tb;

    localparam int OWN  = 32'h8000_0000;
    localparam int WRAP = 32'h4000_0000;
    localparam int CONT = 32'h0800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        pkt_valid, pkt_last, irq;
    logic [7:0]  pkt_data;

    int tests = 0, fails = 0;
    int cap_n = 0, last_n = 0, last_pos = -1, irq_n = 0, wr_n = 0;
    logic [7:0]  cap [0:8299];
    logic [31:0] mem [0:4095];
    bit done_flag = 0;

    always #5 clk = ~clk;

    txring_gather u_dut (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last), .irq(irq)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a & 255) ^ ((a >> 8) * 29));
    endfunction

    // memory model: acknowledge one cycle after a request is seen
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                wr_n++;
                if (mem_addr[31:14] == 0) mem[mem_addr[13:2]] = mem_wdata;
            end else begin
                mem_rdata <= (mem_addr[31:14] == 0) ? mem[mem_addr[13:2]] : 32'hEEEE_EEEE;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && pkt_valid) begin
            if (cap_n < 8300) cap[cap_n] = pkt_data;
            if (pkt_last) begin last_n++; last_pos = cap_n; end
            cap_n++;
        end
        if (rst_n && irq) irq_n++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_desc(input int a, input logic [31:0] w0, input logic [31:0] w1);
        mem[a >> 2] = w0;
        mem[(a >> 2) + 1] = w1;
    endtask

    task automatic park();
        link_up = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    task automatic arm(input int start, input int cur);
        park();
        reg_write(4'h4, start);
        reg_write(4'h8, cur);
        cap_n = 0; last_n = 0; last_pos = -1; irq_n = 0; wr_n = 0;
    endtask

    task automatic wait_irq(input int limit);
        int k = 0;
        while (irq_n == 0 && k < limit) begin @(negedge clk); k++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(irq == 0 && pkt_valid == 0 && mem_req == 0, "R1 reset outputs", {irq, pkt_valid, mem_req}, 0);
        reg_read(4'h4, v); chk(v == 0, "R11 reset start", v, 0);
        reg_read(4'h8, v); chk(v == 0, "R11 reset cur", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        arm(32'h3000, 32'h3040);
        reg_write(4'hC, 32'h1234_5678);
        reg_read(4'hC, v); chk(v == 0, "R11 other offset reads zero", v, 0);
        reg_read(4'h4, v); chk(v == 32'h3000, "R11 start offset 0x04", v, 32'h3000);
        reg_read(4'h8, v); chk(v == 32'h3040, "R11 cur offset 0x08", v, 32'h3040);
    endtask

    task automatic t_start_zero();
        arm(0, 32'h30A0);
        set_desc(32'h30A0, OWN | 1, 32'h50);
        link_up = 1'b1;
        repeat (100) @(negedge clk);
        chk(cap_n == 0 && irq_n == 0 && wr_n == 0, "R1 start zero idle", cap_n + irq_n + wr_n, 0);
        chk(mem[32'h30A0 >> 2] == (OWN | 1), "R1 start zero desc kept", mem[32'h30A0 >> 2], OWN | 1);
    endtask

    task automatic t_link_down();
        logic [31:0] v;
        arm(32'h3000, 32'h30A0);
        repeat (100) @(negedge clk);
        chk(cap_n == 0 && wr_n == 0, "R1 link down idle", cap_n + wr_n, 0);
        reg_read(4'h8, v); chk(v == 32'h30A0, "R1 link down cur kept", v, 32'h30A0);
        link_up = 1'b1;
        wait_irq(500);
        chk(cap_n == 1 && cap[0] == pat(32'h50), "R2 link up sends", cap[0], pat(32'h50));
    endtask

    task automatic t_single();
        logic [31:0] v;
        arm(32'h3000, 32'h3000);
        set_desc(32'h3000, OWN | 32'h0400_0005, 32'h101);
        link_up = 1'b1;
        wait_irq(500);
        chk(cap_n == 5, "R2 single length", cap_n, 5);
        for (int i = 0; i < 5; i++)
            chk(cap[i] == pat(32'h101 + i), "R2 single byte lanes", cap[i], pat(32'h101 + i));
        chk(last_n == 1 && last_pos == 4, "R2 last on final byte", last_pos, 4);
        chk(mem[32'h3000 >> 2] == 32'h0400_0005, "R9 first writeback", mem[32'h3000 >> 2], 32'h0400_0005);
        chk(irq_n == 1, "R9 irq one cycle", irq_n, 1);
        reg_read(4'h8, v); chk(v == 32'h3008, "R7 advance by 8", v, 32'h3008);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        logic [7:0]  e [5];
        arm(32'h3000, 32'h3010);
        set_desc(32'h3010, OWN | CONT | 3, 32'h200);
        set_desc(32'h3018, OWN | CONT | 0, 32'h999);
        set_desc(32'h3020, OWN | WRAP | 2, 32'h2F2);
        e[0] = pat(32'h200); e[1] = pat(32'h201); e[2] = pat(32'h202);
        e[3] = pat(32'h2F2); e[4] = pat(32'h2F3);
        link_up = 1'b1;
        wait_irq(500);
        chk(cap_n == 5 && last_pos == 4, "R3 chain length", cap_n, 5);
        for (int i = 0; i < 5; i++)
            chk(cap[i] == e[i], "R3 chain bytes", cap[i], e[i]);
        chk(mem[32'h3018 >> 2] == 0, "R5 second cleared", mem[32'h3018 >> 2], 0);
        chk(mem[32'h3020 >> 2] == 0, "R5 third cleared", mem[32'h3020 >> 2], 0);
        chk(mem[32'h3010 >> 2] == (CONT | 3), "R9 chain first writeback", mem[32'h3010 >> 2], CONT | 3);
        reg_read(4'h8, v); chk(v == 32'h3000, "R7 wrap to start", v, 32'h3000);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        arm(32'h3000, 32'h3040);
        set_desc(32'h3040, OWN | CONT | 4, 32'h40);
        set_desc(32'h3048, 32'h4, 32'h44);
        link_up = 1'b1;
        repeat (150) @(negedge clk);
        chk(cap_n == 0 && irq_n == 0, "R4 abort no packet", cap_n + irq_n, 0);
        chk(mem[32'h3040 >> 2] == (OWN | CONT | 4), "R4 first unchanged", mem[32'h3040 >> 2], OWN | CONT | 4);
        reg_read(4'h8, v); chk(v == 32'h3048, "R4 cur at unowned", v, 32'h3048);
    endtask

    task automatic t_zero_total();
        logic [31:0] v;
        arm(32'h3000, 32'h3060);
        set_desc(32'h3060, OWN, 32'h80);
        link_up = 1'b1;
        wait_irq(500);
        chk(cap_n == 0, "R8 zero length no packet", cap_n, 0);
        chk(irq_n == 1, "R8 zero length irq", irq_n, 1);
        chk(mem[32'h3060 >> 2] == 0, "R8 zero length writeback", mem[32'h3060 >> 2], 0);
        reg_read(4'h8, v); chk(v == 32'h3068, "R7 zero length advance", v, 32'h3068);
    endtask

    task automatic t_fixup();
        arm(32'h3000, 32'h3080);
        set_desc(32'h3080, OWN | CONT | 2, 32'hC000_0100);
        set_desc(32'h3088, OWN | 2, 32'h4000_0100);
        link_up = 1'b1;
        wait_irq(500);
        chk(cap_n == 4, "R6 fixup length", cap_n, 4);
        chk(cap[0] == pat(32'h100) && cap[1] == pat(32'h101), "R6 both top bits masked", {cap[0], cap[1]}, {pat(32'h100), pat(32'h101)});
        chk(cap[2] == 8'hEE && cap[3] == 8'hEE, "R6 single top bit kept", {cap[2], cap[3]}, 16'hEEEE);
    endtask

    task automatic t_trunc();
        arm(32'h3000, 32'h30C0);
        set_desc(32'h30C0, OWN | CONT | 32'h1FFF, 32'h0);
        set_desc(32'h30C8, OWN | 10, 32'h2000);
        link_up = 1'b1;
        wait_irq(60000);
        chk(cap_n == 8192, "R10 truncated length", cap_n, 8192);
        chk(last_n == 1 && last_pos == 8191, "R10 last at limit", last_pos, 8191);
        chk(cap[0] == pat(0) && cap[8190] == pat(8190), "R10 first part bytes", cap[8190], pat(8190));
        chk(cap[8191] == pat(32'h2000), "R10 final kept byte", cap[8191], pat(32'h2000));
    endtask

    initial begin
        for (int i = 0; i < 4096; i++)
            mem[i] = (i >= 32'hC00) ? 32'h0 :
                     {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_start_zero();
        t_link_down();
        t_single();
        t_chain();
        t_abort();
        t_zero_total();
        t_fixup();
        t_trunc();
        park();
        done_flag = 1;
    end

    initial begin : watchdog
        int n = 0;
        while (!done_flag && n < 150000) begin @(negedge clk); n++; end
        if (!done_flag) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule